// File: doc/BRIEF.md
# Multi-Source Sync Selector

The block hands a synchronization pulse to a set of internal consumers, such as oscillators or an interpolation counter. Each consumer has its own 3-bit selector. The selector picks one of six sources: two external sync pins, a software-triggered one-shot, a free-running periodic counter, a constant high level, or a constant low level. The consumer logic is outside the block.

Both external pins pass through a two-flop synchronizer before they are selected. The one-shot fires on the rising edge of a trigger strobe. The counter produces a one-cycle pulse once per programmed period, and it restarts whenever a new period is written. A separate export output uses the same source encoding. This lets a master device drive its chosen sync off-chip so that other devices can align to it.

Every output is registered, so a change of selection or source appears one clock later.

Top module: `sync_router`

## Requirements
- R1: While `rst_n` is low, every sink output and `sync_out_o` are 0. The period register returns to DEF_PERIOD (16) and the count restarts from zero.
- R2: A selector value of 0, 6 or 7 drives that output to 0 on the next clock.
- R3: A selector value of 5 drives that output to 1 on the next clock.
- R4: Selector 1 follows `ext_a_i` and selector 2 follows `ext_b_i`. A level present at the pin before clock edge k appears at the output after edge k+2.
- R5: Selector 3 gives exactly one one-clock pulse for each 0-to-1 transition of `oneshot_req_i`, however long the trigger stays high. The trigger is high before edge k and the pulse is seen after edge k+1.
- R6: Selector 4 gives a one-clock pulse every P clocks, where P is the period. A period write before edge k sets P and restarts the count, and the first pulse is seen after edge k+P+1. P = 0 gives no pulses.
- R7: Each sink uses its own field `sel_i[3*i+2:3*i]`, with no effect on the other sinks.
- R8: `sync_out_o` uses `exp_sel_i` with the same encoding and latency as the sink outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_a_i | input | 1 | External sync pin A (asynchronous) |
| ext_b_i | input | 1 | External sync pin B (asynchronous) |
| oneshot_req_i | input | 1 | One-shot trigger; rising edge fires |
| period_we_i | input | 1 | Period write strobe |
| period_i | input | CNT_W | Counter period value |
| sel_i | input | 3*NUM_SINKS | Per-sink source selectors |
| exp_sel_i | input | 3 | Source selector for the export output |
| sink_sync_o | output | NUM_SINKS | Per-sink sync pulses |
| sync_out_o | output | 1 | Exported sync for other devices |

## Verification
Faults in the one-shot edge detector show up in the next clock or two as missing pulses or doubled pulses. Counter faults show up as pulses that are early, late or absent within one programmed period of a write. Synchronizer faults show up as an external level arriving a cycle early or late. The bench compares every output on every cycle, so a wrong internal state shows up within one period of the source involved.

// File: rtl/sync_router.sv
module sync_router #(
  parameter int NUM_SINKS = 4,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] DEF_PERIOD = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ext_a_i,
  input  logic                   ext_b_i,
  input  logic                   oneshot_req_i,
  input  logic                   period_we_i,
  input  logic [CNT_W-1:0]       period_i,
  input  logic [3*NUM_SINKS-1:0] sel_i,
  input  logic [2:0]             exp_sel_i,
  output logic [NUM_SINKS-1:0]   sink_sync_o,
  output logic                   sync_out_o
);
  localparam int SEL_W = 3;

  logic a_q1, a_q2, b_q1, b_q2;
  logic req_d, os_p;
  logic [CNT_W-1:0] per, cnt;
  logic tick;
  logic wrap;

  assign wrap = (per != '0) && (cnt == per - 1'b1);

  function automatic logic pick(input logic [SEL_W-1:0] s, input logic a, input logic b,
                                input logic os, input logic tk);
    case (s)
      3'd1: pick = a;
      3'd2: pick = b;
      3'd3: pick = os;
      3'd4: pick = tk;
      3'd5: pick = 1'b1;
      default: pick = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q1 <= 1'b0; a_q2 <= 1'b0; b_q1 <= 1'b0; b_q2 <= 1'b0;
      req_d <= 1'b0; os_p <= 1'b0;
    end else begin
      a_q1 <= ext_a_i; a_q2 <= a_q1;
      b_q1 <= ext_b_i; b_q2 <= b_q1;
      req_d <= oneshot_req_i;
      os_p <= oneshot_req_i & ~req_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per <= DEF_PERIOD; cnt <= '0; tick <= 1'b0;
    end else if (period_we_i) begin
      per <= period_i; cnt <= '0; tick <= 1'b0;
    end else if (wrap) begin
      cnt <= '0; tick <= 1'b1;
    end else begin
      cnt <= (per == '0) ? '0 : cnt + 1'b1; tick <= 1'b0;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_SINKS; i++) begin : g_sink
      always_ff @(posedge clk) begin
        if (!rst_n) sink_sync_o[i] <= 1'b0;
        else sink_sync_o[i] <= pick(sel_i[SEL_W*i +: SEL_W], a_q2, b_q2, os_p, tick);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sync_out_o <= 1'b0;
    else sync_out_o <= pick(exp_sel_i, a_q2, b_q2, os_p, tick);
  end
endmodule

// File: rtl/sync_router_chk.sv
module sync_router_chk #(parameter int NUM_SINKS = 4) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ext_a_i,
  input logic                   oneshot_req_i,
  input logic [3*NUM_SINKS-1:0] sel_i,
  input logic [2:0]             exp_sel_i,
  input logic [NUM_SINKS-1:0]   sink_sync_o,
  input logic                   sync_out_o
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> (sink_sync_o == '0 && !sync_out_o));

  a_r8_export_on: assert property (@(posedge clk) disable iff (!rst_n)
    exp_sel_i == 3'd5 |=> sync_out_o);

  genvar i;
  generate
    for (i = 0; i < NUM_SINKS; i++) begin : g_chk
      a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i[3*i +: 3] == 3'd0 || sel_i[3*i +: 3] >= 3'd6) |=> !sink_sync_o[i]);
      a_r3_on: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i[3*i +: 3] == 3'd5 |=> sink_sync_o[i]);
      a_r4_ext_a: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && sel_i[3*i +: 3] == 3'd1) |=> sink_sync_o[i] == $past(ext_a_i, 3));
      a_r5_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_sync_o[i] && sel_i[3*i +: 3] == 3'd3 && $past(sel_i[3*i +: 3]) == 3'd3) |=> !sink_sync_o[i]);
    end
  endgenerate
endmodule

bind sync_router sync_router_chk #(.NUM_SINKS(NUM_SINKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_a_i(ext_a_i), .oneshot_req_i(oneshot_req_i),
  .sel_i(sel_i), .exp_sel_i(exp_sel_i), .sink_sync_o(sink_sync_o), .sync_out_o(sync_out_o));

// File: tb/sync_router_bench.sv
module sync_router_bench;
  localparam int NS = 4;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_a = 0, ext_b = 0, req = 0, pwe = 0;
  logic [CW-1:0] pval = '0;
  logic [3*NS-1:0] sel = '0;
  logic [2:0] xsel = '0;
  logic [NS-1:0] sink;
  logic sout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_router #(.NUM_SINKS(NS), .CNT_W(CW), .DEF_PERIOD(16)) u_sync_router (
    .clk(clk), .rst_n(rst_n), .ext_a_i(ext_a), .ext_b_i(ext_b), .oneshot_req_i(req),
    .period_we_i(pwe), .period_i(pval), .sel_i(sel), .exp_sel_i(xsel),
    .sink_sync_o(sink), .sync_out_o(sout));

  // reference model built from the requirements
  logic ma1, ma2, mb1, mb2, mreq, mos, mtick;
  int mper, mcnt;
  logic [NS-1:0] esink;
  logic eout;

  function automatic logic src(input logic [2:0] s, input logic a, input logic b,
                               input logic os, input logic tk);
    if (s == 3'd1) return a;
    if (s == 3'd2) return b;
    if (s == 3'd3) return os;
    if (s == 3'd4) return tk;
    if (s == 3'd5) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R3";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ma1 <= 0; ma2 <= 0; mb1 <= 0; mb2 <= 0; mreq <= 0; mos <= 0; mtick <= 0;
      mper <= 16; mcnt <= 0; esink <= '0; eout <= 0;
    end else begin
      ma1 <= ext_a; ma2 <= ma1; mb1 <= ext_b; mb2 <= mb1;
      mreq <= req; mos <= req && !mreq;
      if (pwe) begin mper <= int'(pval); mcnt <= 0; mtick <= 0; end
      else if (mper != 0 && mcnt == mper - 1) begin mcnt <= 0; mtick <= 1; end
      else begin mcnt <= (mper == 0) ? 0 : mcnt + 1; mtick <= 0; end
      for (int i = 0; i < NS; i++) esink[i] <= src(sel[3*i +: 3], ma2, mb2, mos, mtick);
      eout <= src(xsel, ma2, mb2, mos, mtick);
    end
  end

  task automatic compare();
    for (int i = 0; i < NS; i++) begin
      checks++;
      if (sink[i] !== esink[i]) begin
        errors++;
        $display("FAIL %s sink%0d sel=%0d actual=%b expected=%b t=%0t", tag(sel[3*i +: 3]), i,
                 sel[3*i +: 3], sink[i], esink[i], $time);
      end
    end
    checks++;
    if (sout !== eout) begin
      errors++;
      $display("FAIL R8 export actual=%b expected=%b t=%0t", sout, eout, $time);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    sel = {3'd5, 3'd5, 3'd5, 3'd5};
    xsel = 3'd5;
    repeat (3) @(negedge clk);
    checks++;
    if (sink !== '0 || sout !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%b expected=0/0", sink, sout);
    end
    rst_n = 1;
    // R2/R3/R7: distinct selects per sink
    sel = {3'd7, 3'd6, 3'd0, 3'd5};
    xsel = 3'd6;
    step(3);
    // R6: default period after reset, then a short period with restart
    sel = {4{3'd4}}; xsel = 3'd4;
    step(40);
    pval = 3; pwe = 1; step(1); pwe = 0;
    step(12);
    pval = 1; pwe = 1; step(1); pwe = 0;
    step(5);
    pval = 0; pwe = 1; step(1); pwe = 0;
    step(10);
    // R5: held trigger gives one pulse
    sel = {4{3'd3}}; xsel = 3'd3;
    req = 1; step(6); req = 0; step(3);
    req = 1; step(1); req = 0; step(3);
    // R4: external pins
    sel = {3'd2, 3'd1, 3'd2, 3'd1}; xsel = 3'd1;
    ext_a = 1; step(4); ext_b = 1; step(4); ext_a = 0; step(4);
    // R7 random mix
    pval = 5; pwe = 1; step(1); pwe = 0;
    for (int n = 0; n < 4000; n++) begin
      ext_a = $urandom_range(0, 1);
      ext_b = $urandom_range(0, 1);
      req = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) sel = $urandom;
      if ($urandom_range(0, 15) == 0) xsel = $urandom;
      pwe = ($urandom_range(0, 99) == 0);
      pval = $urandom_range(0, 7);
      step(1);
    end
    pwe = 0;
    rst_n = 0; step(0); @(negedge clk); @(negedge clk);
    checks++;
    if (sink !== '0 || sout !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%b expected=0/0", sink, sout);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule